// File: doc/BRIEF.md
# MMU Fault Status Capture Unit

This unit records why a memory access was aborted. On every clock it receives two sets of fault flags, one for the data access and one for the instruction prefetch. The data set holds alignment, translation, domain, permission and external-abort flags. The prefetch set holds the same flags without alignment. Each set carries a section/page size tag and the cacheability attributes of the access. The unit also receives the current domain number and the modified virtual address of the data access.

When several faults are flagged together, a fixed priority picks one of them. The chosen fault is turned into a 4-bit status code and stored. A data abort writes the data status register and loads the fault address register. A prefetch abort writes only the instruction status register.

Software reaches the three registers through a select/write/read port. The read path is combinational. A write takes effect at the next clock edge. If an abort updates a register in the same cycle as a software write to it, the abort's value is the one kept.

Top module: `mmu_fault_capture`

## Requirements
- R1: A data abort records exactly one fault, chosen by this priority from highest to lowest: alignment, translation, domain, permission, qualified external abort.
- R2: Status codes, where S is the page tag (0 = section, 1 = page), are: translation 01S1, domain 10S1, permission 11S1, external abort 10S0.
- R3: An alignment fault records 0001 when parameter ALIGN_ALT is 0 (the default) and 0011 when ALIGN_ALT is 1.
- R4: A data abort writes the data status register with the status in bits [3:0] and the presented domain number, unchecked, in bits [7:4]. Bits above 7 read as zero.
- R5: A data abort loads the fault address register with the virtual address presented in that cycle.
- R6: A prefetch abort writes the instruction status register with the same layout and codes. It never changes the fault address register. The prefetch side has no alignment input.
- R7: A data external abort counts only when the access is noncacheable and also either nonbufferable or a read. Otherwise it is ignored, and if it is the only flag raised, no register changes.
- R8: A prefetch external abort counts only when the fetch is noncacheable.
- R9: After reset, all three registers read zero.
- R10: Register select codes are 0 = data status, 1 = instruction status, 2 = fault address. Status writes keep bits [7:0]. The address write keeps VA_W bits. Code 3 reads zero, and writes to it are ignored.
- R11: An abort that updates a register in the same cycle as a software write to that register takes precedence over the write.
- R12: In a cycle with no counted fault and no write, every register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| d_align | input | 1 | Data alignment fault |
| d_xlat | input | 1 | Data translation fault |
| d_domf | input | 1 | Data domain fault |
| d_perm | input | 1 | Data permission fault |
| d_ext | input | 1 | Data external abort |
| d_page | input | 1 | Data fault size tag, 1 = page |
| d_cacheable | input | 1 | Data access cacheable |
| d_bufferable | input | 1 | Data access bufferable |
| d_read | input | 1 | Data access is a read |
| i_xlat | input | 1 | Prefetch translation fault |
| i_domf | input | 1 | Prefetch domain fault |
| i_perm | input | 1 | Prefetch permission fault |
| i_ext | input | 1 | Prefetch external abort |
| i_page | input | 1 | Prefetch size tag, 1 = page |
| i_cacheable | input | 1 | Prefetch cacheable |
| cur_dom | input | DOM_W | Current domain number |
| mva | input | VA_W | Modified virtual address of the data access |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Software write strobe |
| reg_wdata | input | REG_W | Software write data |
| reg_rdata | output | REG_W | Read data for the selected register |

## Verification
Two kinds of event can land on the same register edge: a software write and an abort. The bench provokes this with directed cycles and also lets it occur at random. The clashes covered are a write to the data status register during a data abort, a write to the instruction status register during a prefetch abort, and a write to the fault address register during a data abort. In each case the register must hold the abort's value. The opposite case is also provoked: a write to the fault address register during a prefetch-only abort, where the written value must survive. A behavioural model applies the write first and the abort second, and the bench compares all three registers against it after every clock.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
   localparam int unsigned ST_W  = 4;
   localparam int unsigned FSR_W = 8;
   localparam int unsigned SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_DFSR = 2'd0,
      SEL_IFSR = 2'd1,
      SEL_FADR = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/mfc_fault_enc.sv
module mfc_fault_enc #(
   parameter bit          IS_DATA   = 1'b1,
   parameter bit          ALIGN_ALT = 1'b0,
   parameter int unsigned ST_W      = 4
) (
   input  logic            align,
   input  logic            xlat,
   input  logic            domf,
   input  logic            perm,
   input  logic            ext,
   input  logic            is_page,
   input  logic            cacheable,
   input  logic            bufferable,
   input  logic            is_read,
   output logic            hit,
   output logic [ST_W-1:0] status
);
   localparam logic [3:0] ALIGN_CODE = ALIGN_ALT ? 4'b0011 : 4'b0001;

   generate
      if (ST_W != 4) begin : g_bad_width
         $error("mfc_fault_enc: ST_W must be 4");
      end
   endgenerate

   logic ext_ok;
   logic align_ok;

   generate
      if (IS_DATA) begin : g_data_qual
         // R7: noncacheable and (nonbufferable or read)
         assign ext_ok   = ext & ~cacheable & (~bufferable | is_read);
         assign align_ok = align;
      end else begin : g_inst_qual
         // R8: noncacheable only; R6: no alignment on prefetch
         logic unused_inst;
         assign unused_inst = ^{bufferable, is_read, align};
         assign ext_ok   = ext & ~cacheable;
         assign align_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      hit    = 1'b1;
      status = '0;
      if (align_ok)  status = ALIGN_CODE;
      else if (xlat) status = {2'b01, is_page, 1'b1};
      else if (domf) status = {2'b10, is_page, 1'b1};
      else if (perm) status = {2'b11, is_page, 1'b1};
      else if (ext_ok) status = {2'b10, is_page, 1'b0};
      else hit = 1'b0;
   end

   always_comb begin
      if (hit) begin
         AST_STATUS_ODD_UNLESS_EXT: assert (status[0] || (ext_ok && !align_ok && !xlat && !domf && !perm)); // R2
      end
   end
endmodule

// File: rtl/mfc_regs.sv
module mfc_regs #(
   parameter int unsigned REG_W = 32,
   parameter int unsigned VA_W  = 32,
   parameter int unsigned FSR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             d_hit,
   input  logic [FSR_W-1:0] d_fsr,
   input  logic             i_hit,
   input  logic [FSR_W-1:0] i_fsr,
   input  logic [VA_W-1:0]  mva,
   input  logic             wr_dfsr,
   input  logic             wr_ifsr,
   input  logic             wr_fadr,
   input  logic [REG_W-1:0] wdata,
   output logic [FSR_W-1:0] dfsr_q,
   output logic [FSR_W-1:0] ifsr_q,
   output logic [VA_W-1:0]  fadr_q
);
   generate
      if (VA_W > REG_W || FSR_W > REG_W) begin : g_bad_width
         $error("mfc_regs: register fields wider than REG_W");
      end
   endgenerate

   // R9 reset, R11 abort after write so abort wins
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dfsr_q <= '0;
         ifsr_q <= '0;
         fadr_q <= '0;
      end else begin
         if (d_hit)        dfsr_q <= d_fsr;
         else if (wr_dfsr) dfsr_q <= wdata[FSR_W-1:0];

         if (i_hit)        ifsr_q <= i_fsr;
         else if (wr_ifsr) ifsr_q <= wdata[FSR_W-1:0];

         if (d_hit)        fadr_q <= mva;
         else if (wr_fadr) fadr_q <= wdata[VA_W-1:0];
      end
   end

   AST_FADR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!d_hit && !wr_fadr) |=> $stable(fadr_q)); // R6
   AST_IFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!i_hit && !wr_ifsr) |=> $stable(ifsr_q)); // R12
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture #(
   parameter int unsigned REG_W     = 32,
   parameter int unsigned VA_W      = 32,
   parameter int unsigned DOM_W     = 4,
   parameter bit          ALIGN_ALT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             d_align,
   input  logic             d_xlat,
   input  logic             d_domf,
   input  logic             d_perm,
   input  logic             d_ext,
   input  logic             d_page,
   input  logic             d_cacheable,
   input  logic             d_bufferable,
   input  logic             d_read,
   input  logic             i_xlat,
   input  logic             i_domf,
   input  logic             i_perm,
   input  logic             i_ext,
   input  logic             i_page,
   input  logic             i_cacheable,
   input  logic [DOM_W-1:0] cur_dom,
   input  logic [VA_W-1:0]  mva,
   input  logic [1:0]       reg_sel,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata
);
   import mfc_pkg::*;

   localparam int unsigned FSR_BITS = ST_W + DOM_W;

   generate
      if (FSR_BITS != FSR_W) begin : g_bad_dom
         $error("mmu_fault_capture: DOM_W must be 4");
      end
   endgenerate

   logic            d_hit, i_hit;
   logic [ST_W-1:0] d_st, i_st;
   logic [FSR_W-1:0] dfsr_q, ifsr_q;
   logic [VA_W-1:0] fadr_q;
   reg_sel_e        sel;

   assign sel = reg_sel_e'(reg_sel);

   mfc_fault_enc #(.IS_DATA(1'b1), .ALIGN_ALT(ALIGN_ALT), .ST_W(ST_W)) u_denc (
      .align(d_align), .xlat(d_xlat), .domf(d_domf), .perm(d_perm), .ext(d_ext),
      .is_page(d_page), .cacheable(d_cacheable), .bufferable(d_bufferable),
      .is_read(d_read), .hit(d_hit), .status(d_st));

   mfc_fault_enc #(.IS_DATA(1'b0), .ALIGN_ALT(ALIGN_ALT), .ST_W(ST_W)) u_ienc (
      .align(1'b0), .xlat(i_xlat), .domf(i_domf), .perm(i_perm), .ext(i_ext),
      .is_page(i_page), .cacheable(i_cacheable), .bufferable(1'b0),
      .is_read(1'b1), .hit(i_hit), .status(i_st));

   mfc_regs #(.REG_W(REG_W), .VA_W(VA_W), .FSR_W(FSR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .d_hit(d_hit), .d_fsr({cur_dom, d_st}),
      .i_hit(i_hit), .i_fsr({cur_dom, i_st}),
      .mva(mva),
      .wr_dfsr(reg_wr && sel == SEL_DFSR),
      .wr_ifsr(reg_wr && sel == SEL_IFSR),
      .wr_fadr(reg_wr && sel == SEL_FADR),
      .wdata(reg_wdata),
      .dfsr_q(dfsr_q), .ifsr_q(ifsr_q), .fadr_q(fadr_q));

   always_comb begin
      unique case (sel)
         SEL_DFSR: reg_rdata = REG_W'(dfsr_q);
         SEL_IFSR: reg_rdata = REG_W'(ifsr_q);
         SEL_FADR: reg_rdata = REG_W'(fadr_q);
         default:  reg_rdata = '0;
      endcase
   end

   AST_ALIGN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      d_align |=> dfsr_q == {$past(cur_dom), (ALIGN_ALT ? 4'b0011 : 4'b0001)}); // R3
   AST_XLAT_OVER_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
      (!d_align && d_xlat) |=> dfsr_q[3:0] == {2'b01, $past(d_page), 1'b1}); // R1
   AST_FADR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (d_align || d_xlat || d_domf || d_perm) |=> fadr_q == $past(mva)); // R5
   AST_IFSR_PERM: assert property (@(posedge clk) disable iff (!rst_n)
      (i_perm && !i_xlat && !i_domf) |=> ifsr_q == {$past(cur_dom), 3'b111, 1'b1} ^ {4'b0, 2'b0, !$past(i_page), 1'b0}); // R6
endmodule

// File: tb/mmu_fault_capture_tb_top.sv
`timescale 1ns/100ps
module mmu_fault_capture_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        d_align, d_xlat, d_domf, d_perm, d_ext, d_page, d_cacheable, d_bufferable, d_read;
   logic        i_xlat, i_domf, i_perm, i_ext, i_page, i_cacheable;
   logic [3:0]  cur_dom;
   logic [31:0] mva;
   logic [1:0]  reg_sel;
   logic        reg_wr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   logic [7:0]  m_dfsr, m_ifsr;
   logic [31:0] m_fadr;

   always #2.5 clk = ~clk;

   mmu_fault_capture dut_i (.*);

   task automatic clear_in();
      {d_align, d_xlat, d_domf, d_perm, d_ext, d_page} = '0;
      {d_cacheable, d_bufferable, d_read} = '0;
      {i_xlat, i_domf, i_perm, i_ext, i_page, i_cacheable} = '0;
      cur_dom = '0; mva = '0; reg_sel = '0; reg_wr = 0; reg_wdata = '0;
   endtask

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // behavioural reference: returns {hit, code}
   function automatic logic [4:0] ref_code(bit is_d, bit al, bit x, bit dm, bit p, bit e,
                                           bit pg, bit c, bit b, bit rd);
      bit e_ok;
      if (is_d) e_ok = e && !c && (!b || rd);
      else      e_ok = e && !c;
      if (is_d && al) return 5'b1_0001;
      if (x)    return pg ? 5'b1_0111 : 5'b1_0101;
      if (dm)   return pg ? 5'b1_1011 : 5'b1_1001;
      if (p)    return pg ? 5'b1_1111 : 5'b1_1101;
      if (e_ok) return pg ? 5'b1_1010 : 5'b1_1000;
      return 5'b0_0000;
   endfunction

   task automatic compare_all(string tag);
      reg_wr = 0;
      reg_sel = 2'd0; #0.5; check({tag, " dfsr"}, reg_rdata, {24'b0, m_dfsr});
      reg_sel = 2'd1; #0.5; check({tag, " ifsr"}, reg_rdata, {24'b0, m_ifsr});
      reg_sel = 2'd2; #0.5; check({tag, " fadr"}, reg_rdata, m_fadr);
   endtask

   task automatic step(string tag);
      logic [4:0] dr, ir;
      @(posedge clk);
      dr = ref_code(1, d_align, d_xlat, d_domf, d_perm, d_ext, d_page, d_cacheable, d_bufferable, d_read);
      ir = ref_code(0, 0, i_xlat, i_domf, i_perm, i_ext, i_page, i_cacheable, 0, 1);
      if (reg_wr) begin
         if (reg_sel == 2'd0) m_dfsr = reg_wdata[7:0];
         if (reg_sel == 2'd1) m_ifsr = reg_wdata[7:0];
         if (reg_sel == 2'd2) m_fadr = reg_wdata;
      end
      if (dr[4]) begin m_dfsr = {cur_dom, dr[3:0]}; m_fadr = mva; end
      if (ir[4]) m_ifsr = {cur_dom, ir[3:0]};
      #0.5;
      compare_all(tag);
      clear_in();
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      clear_in();
      m_dfsr = '0; m_ifsr = '0; m_fadr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      compare_all("R9 reset");

      // R2 single faults, section and page
      for (int pg = 0; pg < 2; pg++) begin
         d_xlat = 1; d_page = pg[0]; cur_dom = 4'h3; mva = 32'h1000_0000 + pg; step("R2 xlat");
         d_domf = 1; d_page = pg[0]; cur_dom = 4'h5; mva = 32'h2000_0000 + pg; step("R2 domain");
         d_perm = 1; d_page = pg[0]; cur_dom = 4'h9; mva = 32'h3000_0000 + pg; step("R2 perm");
         d_ext = 1; d_page = pg[0]; mva = 32'h4000_0000 + pg; step("R2 ext");
      end
      // R3 alignment with all flags, R4 unchecked domain
      d_align = 1; d_xlat = 1; d_domf = 1; d_perm = 1; d_ext = 1; cur_dom = 4'hF; mva = 32'hDEAD_BEEF;
      step("R3 align wins");
      d_domf = 1; d_perm = 1; d_page = 1; cur_dom = 4'hA; step("R4 domain field");
      // R5 address
      d_perm = 1; mva = 32'hCAFE_F00D; step("R5 fadr load");
      // R6 prefetch only
      i_xlat = 1; i_page = 1; cur_dom = 4'h6; mva = 32'h1111_1111; step("R6 prefetch");
      i_perm = 1; i_ext = 1; cur_dom = 4'h2; step("R6 prefetch perm");
      // R7 qualification combos
      for (int k = 0; k < 8; k++) begin
         d_ext = 1; d_cacheable = k[0]; d_bufferable = k[1]; d_read = k[2];
         mva = 32'h5000_0000 + k; cur_dom = k[3:0]; step("R7 ext qualify");
      end
      // R8 prefetch external
      i_ext = 1; i_cacheable = 1; cur_dom = 4'h7; step("R8 cacheable ext ignored");
      i_ext = 1; i_cacheable = 0; cur_dom = 4'h8; step("R8 noncacheable ext");
      // R10 writes
      reg_wr = 1; reg_sel = 2'd0; reg_wdata = 32'hFFFF_FF5A; step("R10 write dfsr");
      reg_wr = 1; reg_sel = 2'd1; reg_wdata = 32'h0000_01C3; step("R10 write ifsr");
      reg_wr = 1; reg_sel = 2'd2; reg_wdata = 32'h8765_4321; step("R10 write fadr");
      reg_wr = 1; reg_sel = 2'd3; reg_wdata = 32'hFFFF_FFFF; step("R10 write none");
      reg_sel = 2'd3; #0.5; check("R10 sel3 reads zero", reg_rdata, 32'h0);
      // R11 clashes
      reg_wr = 1; reg_sel = 2'd0; reg_wdata = 32'h77; d_xlat = 1; cur_dom = 4'h4; mva = 32'h9; step("R11 dfsr clash");
      reg_wr = 1; reg_sel = 2'd1; reg_wdata = 32'h66; i_domf = 1; cur_dom = 4'hB; step("R11 ifsr clash");
      reg_wr = 1; reg_sel = 2'd2; reg_wdata = 32'h55; d_perm = 1; mva = 32'hABCD; step("R11 fadr clash");
      reg_wr = 1; reg_sel = 2'd2; reg_wdata = 32'h44; i_perm = 1; step("R11 fadr write with prefetch");
      // R12 idle
      cur_dom = 4'hE; mva = 32'hFFFF_0000; step("R12 idle hold");

      // R1 random mix
      for (int n = 0; n < 3000; n++) begin
         d_align = ($urandom % 8) == 0; d_xlat = ($urandom % 4) == 0;
         d_domf = ($urandom % 4) == 0;  d_perm = ($urandom % 4) == 0;
         d_ext = ($urandom % 3) == 0;   d_page = $urandom;
         d_cacheable = $urandom; d_bufferable = $urandom; d_read = $urandom;
         i_xlat = ($urandom % 4) == 0; i_domf = ($urandom % 4) == 0;
         i_perm = ($urandom % 4) == 0; i_ext = ($urandom % 3) == 0;
         i_page = $urandom; i_cacheable = $urandom;
         cur_dom = $urandom; mva = $urandom;
         reg_wr = ($urandom % 6) == 0; reg_sel = $urandom; reg_wdata = $urandom;
         step("R1 random");
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule